// File: doc/BRIEF.md
# Parallel TDM Port Framer and Byte Switch

This block sits on a byte-wide time-division backplane port. Every clock carries one byte channel. A frame repeats at 8 kHz and holds one of three channel counts, picked by a static rate setting. The receive side counts incoming bytes from a receive frame pulse and stores each frame in one half of a double-buffered frame store. The transmit side counts outgoing channels and reads a connection memory entry for each one. The entry names the input channel to forward, four per-byte control lines, and a disable bit for the output drivers. The transmit side then launches the byte one clock later, together with its control lines, its enable and the transmit frame pulse.

The transmit frame timing has two sources. As master, the block generates the frame pulse itself. As slave, it follows an external pulse, so that several ports can share one timing source. The pulse polarity can be set, and the output register stage can launch on the rising or the falling clock edge. A bypass setting replaces the switched byte with the byte arriving on the input in the same clock, for add/drop use.

Switching assumes that receive and transmit frames start in the same clock. There is no elastic buffer to absorb a phase offset between them. Under that assumption, every output frame is built from one complete input frame, the one before it.

Top module: `tdm_par_switch`

## Requirements
- R1: While reset is asserted, tx_data_o, tx_ctl_o, tx_oe_o and tx_fp_o are all 0.
- R2: The frame length follows rate_sel_i: 0 gives 2430 channels, 1 gives 2048, 2 gives 810 and 3 gives 2430. In master mode the transmit frame pulse repeats every frame-length clocks. The first pulse is in the first output clock after reset is released.
- R3: With fp_pol_i=1 the transmit frame pulse is active high; with fp_pol_i=0 it is active low. The setting applies to both tx_fp_o and tx_fp_i. tx_fp_o is at the active level exactly in the clock that carries output channel 0.
- R4: With fp_slave_i=1, tx_fp_i at the active level makes that clock transmit channel 0, and channel 0 is launched in the next clock. An early pulse restarts the count. When a pulse is missing, the count wraps at the frame length. tx_fp_oe_o is the inverse of fp_slave_i.
- R5: With fp_slave_i=0, tx_fp_i has no effect on any output.
- R6: With bypass off, the byte output for transmit channel k is the byte received at input channel src(k) in the previous receive frame. The output clock is the one after the transmit count reaches k.
- R7: rx_fp_i high marks the byte on rx_data_i in that clock as receive channel 0, and an early pulse restarts the receive count. Without pulses, the receive count wraps at the frame length.
- R8: With bypass_i=1, tx_data_o equals the rx_data_i of the clock before.
- R9: tx_ctl_o carries the ctl field of the connection entry of the channel being output, in the same clock as that channel's byte.
- R10: tx_oe_o is 0 in a channel whose connection entry has hiz=1, and 1 otherwise.
- R11: With tx_fall_i=1, every transmit output changes half a clock later, on the falling edge, and carries the same values.
- R12: A connection memory write stores cm_wdata_i at cm_addr_i on the clock edge. The fields are src=[11:0], ctl=[15:12] and hiz=[16]. A read in the same clock returns the old entry, and reads in later clocks return the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, one channel per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 2 | Frame length select |
| tx_fall_i | input | 1 | 1: launch transmit outputs on the falling edge |
| fp_pol_i | input | 1 | Active level of the transmit frame pulse |
| fp_slave_i | input | 1 | 1: follow tx_fp_i; 0: generate the frame pulse |
| bypass_i | input | 1 | 1: pass the input byte straight to the output |
| cm_we_i | input | 1 | Connection memory write strobe |
| cm_addr_i | input | 12 | Connection memory write address (output channel) |
| cm_wdata_i | input | 17 | Connection entry {hiz, ctl[3:0], src[11:0]} |
| rx_fp_i | input | 1 | Receive frame pulse, active high, on channel 0 |
| rx_data_i | input | 8 | Receive byte |
| tx_fp_i | input | 1 | External transmit frame pulse (slave mode) |
| tx_fp_o | output | 1 | Transmit frame pulse |
| tx_fp_oe_o | output | 1 | Drive enable for the transmit frame pulse |
| tx_data_o | output | 8 | Transmit byte |
| tx_ctl_o | output | 4 | Per-byte control lines |
| tx_oe_o | output | 1 | Per-byte data output enable |

## Verification
Two functions can fall in the same clock. A connection memory write can hit the entry the transmit side is reading. A receive frame start can swap the frame store banks in the clock where the switch reads the bank that was just filled. The first case is provoked by random live writes to random entries during the 2048-channel run. The second occurs at every aligned frame start, and at the early and missing slave pulses, where both counters restart together. They are judged by the bench's own model. In that model, an entry written in a clock takes effect from the next clock, and every output byte must come from the last complete input frame. Bytes not written in that frame are excluded from the comparison.

// File: rtl/tdm_par_pkg.sv
package tdm_par_pkg;

  localparam int CH_W   = 12;
  localparam int CTL_W  = 4;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic             hiz;
    logic [CTL_W-1:0] ctl;
    logic [CH_W-1:0]  src;
  } cm_word_t;

  localparam int CM_W = $bits(cm_word_t);

  // last channel index of a frame for a rate code; code 3 falls back to the full rate
  function automatic logic [CH_W-1:0] last_chan(input logic [1:0] rate,
                                                input int n_full, input int n_mid,
                                                input int n_low);
    case (rate)
      2'd1:    return CH_W'(n_mid - 1);
      2'd2:    return CH_W'(n_low - 1);
      default: return CH_W'(n_full - 1);
    endcase
  endfunction

  // advance a channel index, wrapping after the last one (or any larger value)
  function automatic logic [CH_W-1:0] chan_step(input logic [CH_W-1:0] q,
                                                input logic [CH_W-1:0] last);
    return (q >= last) ? '0 : q + 1'b1;
  endfunction

  // frame pulse line level for a channel-0 flag and a polarity
  function automatic logic fp_level(input logic sof, input logic pol);
    return sof ? pol : ~pol;
  endfunction

endpackage

// File: rtl/tdm_chan_ctr.sv
module tdm_chan_ctr
  import tdm_par_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [CH_W-1:0] last,
  output logic [CH_W-1:0] ch
);

  logic [CH_W-1:0] ch_q;

  // the channel of the current clock; reset value wraps to 0 on the first clock
  assign ch = restart ? '0 : chan_step(ch_q, last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_q <= '1;
    else        ch_q <= ch;
  end

endmodule

// File: rtl/tdm_conn_mem.sv
module tdm_conn_mem
  import tdm_par_pkg::*;
#(
  parameter int DEPTH = 2430
) (
  input  logic            clk,
  input  logic            we,
  input  logic [CH_W-1:0] wr_addr,
  input  cm_word_t        wr_data,
  input  logic [CH_W-1:0] rd_addr,
  output cm_word_t        rd_data
);

  localparam logic [CH_W-1:0] DEPTH_A = CH_W'(DEPTH);

  cm_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (wr_addr < DEPTH_A)) mem[wr_addr] <= wr_data;
  end

  assign rd_data = (rd_addr < DEPTH_A) ? mem[rd_addr] : '0;

endmodule

// File: rtl/tdm_frame_store.sv
module tdm_frame_store
  import tdm_par_pkg::*;
#(
  parameter int DEPTH = 2430
) (
  input  logic              clk,
  input  logic              wr_bank,
  input  logic [CH_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [CH_W-1:0]   rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int              N_BANK  = 2;
  localparam logic [CH_W-1:0] DEPTH_A = CH_W'(DEPTH);

  logic [DATA_W-1:0] bank_rd [N_BANK];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if ((wr_bank == 1'(b)) && (wr_addr < DEPTH_A)) mem[wr_addr] <= wr_data;
    end

    assign bank_rd[b] = (rd_addr < DEPTH_A) ? mem[rd_addr] : '0;
  end

  assign rd_data = rd_bank ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/tdm_tx_launch.sv
module tdm_tx_launch
  import tdm_par_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_sel,
  input  logic              in_fp,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTL_W-1:0]  in_ctl,
  input  logic              in_oe,
  output logic              out_fp,
  output logic [DATA_W-1:0] out_data,
  output logic [CTL_W-1:0]  out_ctl,
  output logic              out_oe
);

  localparam int W = 1 + DATA_W + CTL_W + 1;

  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;
  logic [W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= {in_fp, in_data, in_ctl, in_oe};
  end

  // half-cycle retime of the rising-edge stage for falling-edge launch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= rise_q;
  end

  assign sel = fall_sel ? fall_q : rise_q;
  assign {out_fp, out_data, out_ctl, out_oe} = sel;

endmodule

// File: rtl/tdm_par_switch.sv
module tdm_par_switch
  import tdm_par_pkg::*;
#(
  parameter int N_FULL = 2430,
  parameter int N_MID  = 2048,
  parameter int N_LOW  = 810
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rate_sel_i,
  input  logic              tx_fall_i,
  input  logic              fp_pol_i,
  input  logic              fp_slave_i,
  input  logic              bypass_i,
  input  logic              cm_we_i,
  input  logic [CH_W-1:0]   cm_addr_i,
  input  logic [CM_W-1:0]   cm_wdata_i,
  input  logic              rx_fp_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_fp_i,
  output logic              tx_fp_o,
  output logic              tx_fp_oe_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [CTL_W-1:0]  tx_ctl_o,
  output logic              tx_oe_o
);

  localparam int DEPTH = N_FULL;

  logic [CH_W-1:0]   last;
  logic [CH_W-1:0]   rx_ch;
  logic [CH_W-1:0]   tx_ch;
  logic              rx_sof;
  logic              tx_sof;
  logic              tx_pulse_in;
  logic              bank_q;
  logic              wr_bank;
  logic              rd_bank;
  cm_word_t          cm_rd;
  logic              cm_hiz;
  logic [CTL_W-1:0]  cm_ctl;
  logic [DATA_W-1:0] sw_byte;
  logic [DATA_W-1:0] pre_data;
  logic              pre_fp;

  assign last = last_chan(rate_sel_i, N_FULL, N_MID, N_LOW);

  // receive channel count, restarted by the receive frame pulse
  tdm_chan_ctr rx_ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rx_fp_i),
    .last    (last),
    .ch      (rx_ch)
  );

  // transmit channel count, restarted only by an external pulse in slave mode
  assign tx_pulse_in = fp_slave_i && (tx_fp_i == fp_pol_i);

  tdm_chan_ctr tx_ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tx_pulse_in),
    .last    (last),
    .ch      (tx_ch)
  );

  assign rx_sof = (rx_ch == '0);
  assign tx_sof = (tx_ch == '0);

  // the bank being filled flips at every receive frame start; the other one is read
  assign wr_bank = rx_sof ? ~bank_q : bank_q;
  assign rd_bank = ~wr_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= 1'b0;
    else        bank_q <= wr_bank;
  end

  tdm_conn_mem #(.DEPTH(DEPTH)) cm_i (
    .clk     (clk),
    .we      (cm_we_i),
    .wr_addr (cm_addr_i),
    .wr_data (cm_word_t'(cm_wdata_i)),
    .rd_addr (tx_ch),
    .rd_data (cm_rd)
  );

  assign cm_hiz = cm_rd.hiz;
  assign cm_ctl = cm_rd.ctl;

  tdm_frame_store #(.DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .wr_bank (wr_bank),
    .wr_addr (rx_ch),
    .wr_data (rx_data_i),
    .rd_bank (rd_bank),
    .rd_addr (cm_rd.src),
    .rd_data (sw_byte)
  );

  assign pre_data = bypass_i ? rx_data_i : sw_byte;
  assign pre_fp   = fp_level(tx_sof, fp_pol_i);

  tdm_tx_launch launch_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_sel (tx_fall_i),
    .in_fp    (pre_fp),
    .in_data  (pre_data),
    .in_ctl   (cm_ctl),
    .in_oe    (~cm_hiz),
    .out_fp   (tx_fp_o),
    .out_data (tx_data_o),
    .out_ctl  (tx_ctl_o),
    .out_oe   (tx_oe_o)
  );

  assign tx_fp_oe_o = ~fp_slave_i;

endmodule

// File: rtl/tdm_par_switch_chk.sv
module tdm_par_switch_chk
  import tdm_par_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_fall_i,
  input logic              fp_pol_i,
  input logic              fp_slave_i,
  input logic              bypass_i,
  input logic              rx_fp_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              tx_fp_i,
  input logic              tx_fp_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic [CTL_W-1:0]  tx_ctl_o,
  input logic              tx_oe_o,
  input logic [CH_W-1:0]   rx_ch,
  input logic [CH_W-1:0]   tx_ch,
  input logic              tx_sof,
  input logic              cm_hiz,
  input logic [CTL_W-1:0]  cm_ctl
);

  // R7
  rx_pulse_chan0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fp_i |-> (rx_ch == '0));

  // R4
  tx_slave_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_slave_i && (tx_fp_i == fp_pol_i)) |-> (tx_ch == '0));

  // R3
  tx_fp_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fall_i && tx_sof) |=> (tx_fp_o == fp_pol_i));

  // R3
  tx_fp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fall_i && !tx_sof) |=> (tx_fp_o != fp_pol_i));

  // R10
  tx_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fall_i && cm_hiz) |=> !tx_oe_o);

  // R9
  tx_ctl_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fall_i |=> (tx_ctl_o == $past(cm_ctl)));

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_fall_i && bypass_i) |=> (tx_data_o == $past(rx_data_i)));

endmodule

bind tdm_par_switch tdm_par_switch_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_fall_i  (tx_fall_i),
  .fp_pol_i   (fp_pol_i),
  .fp_slave_i (fp_slave_i),
  .bypass_i   (bypass_i),
  .rx_fp_i    (rx_fp_i),
  .rx_data_i  (rx_data_i),
  .tx_fp_i    (tx_fp_i),
  .tx_fp_o    (tx_fp_o),
  .tx_data_o  (tx_data_o),
  .tx_ctl_o   (tx_ctl_o),
  .tx_oe_o    (tx_oe_o),
  .rx_ch      (rx_ch),
  .tx_ch      (tx_ch),
  .tx_sof     (tx_sof),
  .cm_hiz     (cm_hiz),
  .cm_ctl     (cm_ctl)
);

// File: tb/tdm_par_switch_tb_top.sv
module tdm_par_switch_tb_top;
  import tdm_par_pkg::*;

  localparam int NF = 2430;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  rate_sel_i = 2'd0;
  logic        tx_fall_i = 1'b0, fp_pol_i = 1'b1, fp_slave_i = 1'b0, bypass_i = 1'b0;
  logic        cm_we_i = 1'b0;
  logic [11:0] cm_addr_i = '0;
  logic [16:0] cm_wdata_i = '0;
  logic        rx_fp_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        tx_fp_i = 1'b0;
  logic        tx_fp_o, tx_fp_oe_o, tx_oe_o;
  logic [7:0]  tx_data_o;
  logic [3:0]  tx_ctl_o;

  tdm_par_switch dut_i (
    .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel_i), .tx_fall_i(tx_fall_i),
    .fp_pol_i(fp_pol_i), .fp_slave_i(fp_slave_i), .bypass_i(bypass_i),
    .cm_we_i(cm_we_i), .cm_addr_i(cm_addr_i), .cm_wdata_i(cm_wdata_i),
    .rx_fp_i(rx_fp_i), .rx_data_i(rx_data_i), .tx_fp_i(tx_fp_i),
    .tx_fp_o(tx_fp_o), .tx_fp_oe_o(tx_fp_oe_o), .tx_data_o(tx_data_o),
    .tx_ctl_o(tx_ctl_o), .tx_oe_o(tx_oe_o)
  );

  typedef struct {
    bit         v;
    bit         fp;
    bit         dchk;
    logic [7:0] d;
    logic [3:0] ctl;
    bit         oe;
  } exp_t;

  int n_chk = 0, n_bad = 0;
  bit done = 0, chk_en = 0;
  exp_t ecur, enx;
  logic [16:0] cm_m  [NF];
  logic [7:0]  cur_d [NF];
  logic [7:0]  prv_d [NF];
  bit          cur_ok[NF];
  bit          prv_ok[NF];
  int m_rx, m_tx, flen, cyc = 0, last_fp;
  string tag_fp, tag_d;

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int len_of(logic [1:0] r);
    case (r)
      2'd1:    return 2048;
      2'd2:    return 810;
      default: return 2430;
    endcase
  endfunction

  function automatic int nxt(int c);
    return (c >= flen - 1) ? 0 : c + 1;
  endfunction

  task automatic cmp_out(exp_t e, string ftag, string dtag);
    chk(ftag, int'(tx_fp_o), int'(e.fp));
    if (e.dchk) chk(dtag, int'(tx_data_o), int'(e.d));
    chk("R9 ctl lines", int'(tx_ctl_o), int'(e.ctl));
    chk("R10 output enable", int'(tx_oe_o), int'(e.oe));
  endtask

  // one byte clock: check the previous interval, drive and model this one
  task automatic step(bit rfp, logic [7:0] rd, logic tfp, bit we, int wa, logic [16:0] wd);
    cm_word_t w;
    if (ecur.v) begin
      cmp_out(ecur, tag_fp, tag_d);
      if (!fp_slave_i && (tx_fp_o == fp_pol_i)) begin
        if (last_fp >= 0) chk("R2 frame length", cyc - last_fp, flen);
        last_fp = cyc;
      end
    end
    rx_fp_i = rfp; rx_data_i = rd; tx_fp_i = tfp;
    cm_we_i = we; cm_addr_i = 12'(wa); cm_wdata_i = wd;
    m_rx = rfp ? 0 : nxt(m_rx);
    if (m_rx == 0) begin
      for (int i = 0; i < NF; i++) begin
        prv_d[i] = cur_d[i]; prv_ok[i] = cur_ok[i]; cur_ok[i] = 0;
      end
    end
    cur_d[m_rx] = rd; cur_ok[m_rx] = 1;
    m_tx = (fp_slave_i && (tfp == fp_pol_i)) ? 0 : nxt(m_tx);
    w = cm_word_t'(cm_m[m_tx]);
    enx.v   = chk_en;
    enx.fp  = (m_tx == 0) ? fp_pol_i : !fp_pol_i;
    enx.ctl = w.ctl;
    enx.oe  = !w.hiz;
    if (bypass_i) begin
      enx.d = rd; enx.dchk = 1;
    end else begin
      enx.dchk = (int'(w.src) < NF) && prv_ok[w.src];
      enx.d    = (int'(w.src) < NF) ? prv_d[w.src] : 8'h00;
    end
    if (we) cm_m[wa] = wd;
    @(posedge clk);
    cyc++;
    if (tx_fall_i) begin
      #1;
      if (ecur.v) cmp_out(ecur, "R11 fall launch fp", "R11 fall launch data");
      #2;
    end else begin
      #3;
    end
    ecur = enx;
  endtask

  task automatic do_reset(logic [1:0] r, bit fall, bit pol, bit slave, bit byp);
    rst_n = 1'b0;
    rate_sel_i = r; tx_fall_i = fall; fp_pol_i = pol; fp_slave_i = slave; bypass_i = byp;
    rx_fp_i = 1'b0; tx_fp_i = ~pol; cm_we_i = 1'b0;
    #1;
    chk("R1 reset data", int'(tx_data_o), 0);
    chk("R1 reset ctl", int'(tx_ctl_o), 0);
    chk("R1 reset oe", int'(tx_oe_o), 0);
    chk("R1 reset fp", int'(tx_fp_o), 0);
    chk("R4 fp drive enable", int'(tx_fp_oe_o), int'(!slave));
    repeat (2) @(posedge clk);
    #3;
    rst_n = 1'b1;
    flen = len_of(r);
    m_rx = flen - 1; m_tx = flen - 1;
    for (int i = 0; i < NF; i++) begin
      cur_ok[i] = 0; prv_ok[i] = 0;
    end
    ecur.v = 0; last_fp = -1;
  endtask

  function automatic logic [16:0] rand_entry(int i);
    logic [11:0] s;
    s = (i % 3 == 0) ? 12'($urandom % NF) : 12'($urandom % 810);
    return {($urandom % 8) == 0, 4'($urandom), s};
  endfunction

  task automatic run_master(int nfr, bit noise, bit live);
    for (int k = 0; k < nfr * flen; k++) begin
      bit we;
      int wa;
      we = live && (($urandom % 16) == 0);
      wa = $urandom % NF;
      step(nxt(m_tx) == 0, 8'($urandom), noise ? 1'($urandom) : ~fp_pol_i,
           we, wa, rand_entry(wa));
    end
  endtask

  task automatic run_slave();
    bit skipped = 0;
    for (int k = 0; k < 6 * flen; k++) begin
      bit p;
      p = (nxt(m_tx) == 0);
      if (p && (k > 3 * flen) && !skipped) begin
        p = 0; skipped = 1;          // missing pulse: counts must wrap by themselves
      end
      if (k == 2 * flen + 400) p = 1; // early pulse: counts restart
      step(p, 8'($urandom), p ? fp_pol_i : ~fp_pol_i, 0, 0, '0);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a11c));
    for (int i = 0; i < NF; i++) cm_m[i] = '0;
    tag_fp = "R2"; tag_d = "R6";

    // full rate master, program every entry during the first frame (R12 entries)
    do_reset(2'd0, 0, 1, 0, 0);
    chk_en = 0;
    for (int i = 0; i < NF; i++)
      step(nxt(m_tx) == 0, 8'($urandom), ~fp_pol_i, 1, i, rand_entry(i));
    // R5: noise on tx_fp_i in master mode, R6 switching
    chk_en = 1; tag_fp = "R5 master ignores tx_fp_i"; tag_d = "R6 switch";
    run_master(4, 1, 0);

    // 2048 channels, active-low pulse, live connection writes (R3, R12)
    do_reset(2'd1, 0, 0, 0, 0);
    tag_fp = "R3 polarity"; tag_d = "R12 live cm write";
    run_master(3, 0, 1);

    // 810 channels, falling-edge launch (R11, R2)
    do_reset(2'd2, 1, 1, 0, 0);
    tag_fp = "R2 frame pulse"; tag_d = "R6 switch";
    run_master(4, 0, 0);

    // 810 channels slave with early and missing pulses (R4, R7)
    do_reset(2'd2, 0, 0, 1, 0);
    tag_fp = "R4 slave frame"; tag_d = "R7 rx restart";
    run_slave();

    // bypass (R8)
    do_reset(2'd1, 0, 1, 0, 1);
    tag_fp = "R2 frame pulse"; tag_d = "R8 bypass";
    run_master(2, 0, 0);

    // rate code 3 falls back to full length (R2)
    do_reset(2'd3, 0, 1, 0, 0);
    tag_fp = "R2 rate code 3"; tag_d = "R6 switch";
    run_master(2, 0, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule